// File: doc/BRIEF.md
# Power and Sleep Controller

This block controls power for a small set of power domains and the clock-gated modules inside them. It has a 32-bit register bus with 4-byte word spacing. Software writes the state it wants for each module and whether each domain should be on. Nothing changes until software writes a go bit for a domain. Each domain has its own sequencer, which then runs the transition for that domain's modules.

A domain that is off and is asked to power on first raises a request to an external power switch. It then waits until software reports power good. After that the domain turns on and its modules take their new states. Status registers report, per domain, a busy flag, a pending power request and the power state. Per module they report the current state and a clock-active flag. Each module drives a clock-gate enable and an active-low reset. Module `m` belongs to domain `m / MODS_PER_DOM`.

Top module: `pwr_sleep_ctrl`

## Requirements
- R1: After reset the following values hold:
  - every domain status word reads 1 (on), and every domain control word reads 0x001;
  - the busy and pending words read 0;
  - every module status word reads 0, and every module control word reads 0x100;
  - every `mod_clk_en_o` bit is 0 and every `mod_rst_no` bit is 0.
- R2: A go write is a write to 0x120 with bit n set. If domain n is on, busy bit n (register 0x128) is 1 for exactly TRANS_CYC cycles. At the edge where busy bit n clears, every module of domain n takes the state held in bits [1:0] of its control word (0xA00+4m).
- R3: Module status (0x800+4m) shows the state in bits [5:0]. The encodings are 0 = software reset with clock off, 1 = synchronous reset, 2 = clock disabled and 3 = enabled. Bit 12 and `mod_clk_en_o[m]` are 1 exactly when the state is 3.
- R4: `mod_rst_no[m]` is low when the state is 0 or 1, or when bit 8 of the module control word is 0. Writing bit 8 takes effect on the next cycle whether or not a transition is running, and it does not change the state.
- R5: A go write to a domain that is off while its control bit 0 is 1 does three things:
  - it sets bit n of the pending word (0x070) and `pwr_req_o[n]`, and sets busy bit n;
  - the modules do not change state while the request is pending;
  - once bit 8 (power good) of the domain control word (0x300+4n) is written as 1, pending clears on the next edge, the domain status (0x200+4n) reads 1, and the modules transition TRANS_CYC cycles later.
- R6: The power-good bit clears itself once the handshake has used it.
- R7: A go write to a domain that is on while its control bit 0 is 0 runs the module transitions. The domain status then reads 0 from the same edge where busy clears.
- R8: A go write to a domain that is off while its control bit 0 is 0 updates only the modules whose control bit 31 (force) is 1. The other modules keep their state.
- R9: A go write to a domain that is already busy is ignored, and the running transition keeps its original end cycle.
- R10: Reading 0x120 or any unmapped address returns 0.
- R11: A transition in one domain leaves the modules of every other domain unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_req_i | input | 1 | Bus access strobe |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 12 | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid in the same cycle as the read strobe |
| pwr_req_o | output | NUM_DOM | Power-switch request per domain |
| mod_clk_en_o | output | NUM_DOM*MODS_PER_DOM | Clock-gate enable per module |
| mod_rst_no | output | NUM_DOM*MODS_PER_DOM | Module reset, active low |

## Verification
Read data is combinational, so it is sampled in the same cycle as the read strobe. Control writes show in the outputs from the cycle after the write edge. A go write accepted at edge e raises busy after e, and the module states change and busy drops at edge e+TRANS_CYC. A power-good write at edge j clears pending at edge j+1, and the modules move at edge j+1+TRANS_CYC. The bench drives inputs and samples outputs on falling edges. Its behavioural model steps on every rising edge, and the outputs are compared with it on every falling edge. The busy checks for R9 are placed on the falling edges just before and just after edge e+TRANS_CYC.

// File: rtl/pwr_pkg.sv
package pwr_pkg;
  typedef enum logic [1:0] {
    MST_SWRST   = 2'd0,
    MST_SYNCRST = 2'd1,
    MST_GATED   = 2'd2,
    MST_ON      = 2'd3
  } mod_state_e;

  typedef enum logic [1:0] {
    SEQ_IDLE    = 2'd0,
    SEQ_WAIT_PG = 2'd1,
    SEQ_RUN     = 2'd2
  } seq_state_e;

  localparam logic [11:0] A_PEND  = 12'h070;
  localparam logic [11:0] A_GO    = 12'h120;
  localparam logic [11:0] A_BUSY  = 12'h128;
  localparam logic [11:0] A_DSTAT = 12'h200;
  localparam logic [11:0] A_DCTL  = 12'h300;
  localparam logic [11:0] A_MSTAT = 12'h800;
  localparam logic [11:0] A_MCTL  = 12'hA00;
endpackage

// File: rtl/pwr_dom_seq.sv
module pwr_dom_seq
  import pwr_pkg::*;
#(
  parameter int TRANS_CYC = 4,
  localparam int CW = $clog2(TRANS_CYC + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic go_i,
  input  logic next_on_i,
  input  logic pg_wr_i,
  output logic busy_o,
  output logic pend_o,
  output logic on_o,
  output logic pg_o,
  output logic done_o
);
  seq_state_e state_q;
  logic [CW-1:0] cnt_q;
  logic on_q, nxt_q, pend_q, pg_q, consume;

  assign consume = (state_q == SEQ_WAIT_PG) && pg_q;
  assign done_o  = (state_q == SEQ_RUN) && (cnt_q == '0);
  assign busy_o  = (state_q != SEQ_IDLE);
  assign pend_o  = pend_q;
  assign on_o    = on_q;
  assign pg_o    = pg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEQ_IDLE;
      cnt_q   <= '0;
      on_q    <= 1'b1;
      nxt_q   <= 1'b1;
      pend_q  <= 1'b0;
      pg_q    <= 1'b0;
    end else begin
      pg_q <= pg_wr_i | (pg_q & ~consume);
      case (state_q)
        SEQ_IDLE: if (go_i) begin
          nxt_q <= next_on_i;
          if (!on_q && next_on_i) begin
            state_q <= SEQ_WAIT_PG;
            pend_q  <= 1'b1;
          end else begin
            state_q <= SEQ_RUN;
            cnt_q   <= CW'(TRANS_CYC - 1);
          end
        end
        SEQ_WAIT_PG: if (pg_q) begin
          pend_q  <= 1'b0;
          on_q    <= 1'b1;
          state_q <= SEQ_RUN;
          cnt_q   <= CW'(TRANS_CYC - 1);
        end
        SEQ_RUN: begin
          if (cnt_q == '0) begin
            state_q <= SEQ_IDLE;
            on_q    <= nxt_q;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pwr_mod_unit.sv
module pwr_mod_unit
  import pwr_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ctl_we_i,
  input  logic [1:0] req_i,
  input  logic       lrel_i,
  input  logic       force_i,
  input  logic       done_i,
  input  logic       dom_on_i,
  output logic [1:0] state_o,
  output logic [31:0] ctl_rd_o,
  output logic       clk_en_o,
  output logic       rst_no
);
  mod_state_e state_q;
  logic [1:0] req_q;
  logic lrel_q, force_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= MST_SWRST;
      req_q   <= 2'd0;
      lrel_q  <= 1'b1;
      force_q <= 1'b0;
    end else begin
      // the domain must be powered unless force is set
      if (done_i && (dom_on_i || force_q)) state_q <= mod_state_e'(req_q);
      if (ctl_we_i) begin
        req_q   <= req_i;
        lrel_q  <= lrel_i;
        force_q <= force_i;
      end
    end
  end

  assign state_o  = state_q;
  assign clk_en_o = (state_q == MST_ON);
  assign rst_no   = lrel_q && (state_q == MST_GATED || state_q == MST_ON);
  assign ctl_rd_o = {force_q, 22'd0, lrel_q, 6'd0, req_q};
endmodule

// File: rtl/pwr_sleep_ctrl.sv
module pwr_sleep_ctrl
  import pwr_pkg::*;
#(
  parameter int NUM_DOM      = 2,
  parameter int MODS_PER_DOM = 2,
  parameter int TRANS_CYC    = 4,
  localparam int NUM_MOD     = NUM_DOM * MODS_PER_DOM
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               bus_req_i,
  input  logic               bus_we_i,
  input  logic [11:0]        bus_addr_i,
  input  logic [31:0]        bus_wdata_i,
  output logic [31:0]        bus_rdata_o,
  output logic [NUM_DOM-1:0] pwr_req_o,
  output logic [NUM_MOD-1:0] mod_clk_en_o,
  output logic [NUM_MOD-1:0] mod_rst_no
);
  logic wr;
  logic [NUM_DOM-1:0] dom_busy, dom_pend, dom_on, dom_pg, dom_done, dom_next_q;
  logic [NUM_MOD-1:0][1:0]  mod_state;
  logic [NUM_MOD-1:0][31:0] mod_ctl;
  logic unused_wdata;

  assign wr           = bus_req_i && bus_we_i;
  assign unused_wdata = ^bus_wdata_i;
  assign pwr_req_o    = dom_pend;

  for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
    logic dctl_wr;
    assign dctl_wr = wr && (bus_addr_i == 12'(A_DCTL + 4 * d));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      dom_next_q[d] <= 1'b1;
      else if (dctl_wr) dom_next_q[d] <= bus_wdata_i[0];
    end

    pwr_dom_seq #(.TRANS_CYC(TRANS_CYC)) u_seq (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .go_i      (wr && bus_addr_i == A_GO && bus_wdata_i[d]),
      .next_on_i (dom_next_q[d]),
      .pg_wr_i   (dctl_wr && bus_wdata_i[8]),
      .busy_o    (dom_busy[d]),
      .pend_o    (dom_pend[d]),
      .on_o      (dom_on[d]),
      .pg_o      (dom_pg[d]),
      .done_o    (dom_done[d])
    );
  end

  for (genvar m = 0; m < NUM_MOD; m++) begin : g_mod
    localparam int D = m / MODS_PER_DOM;
    pwr_mod_unit u_mod (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .ctl_we_i (wr && (bus_addr_i == 12'(A_MCTL + 4 * m))),
      .req_i    (bus_wdata_i[1:0]),
      .lrel_i   (bus_wdata_i[8]),
      .force_i  (bus_wdata_i[31]),
      .done_i   (dom_done[D]),
      .dom_on_i (dom_on[D]),
      .state_o  (mod_state[m]),
      .ctl_rd_o (mod_ctl[m]),
      .clk_en_o (mod_clk_en_o[m]),
      .rst_no   (mod_rst_no[m])
    );
  end

  always_comb begin
    bus_rdata_o = '0;
    if (bus_req_i && !bus_we_i) begin
      if (bus_addr_i == A_PEND) bus_rdata_o[NUM_DOM-1:0] = dom_pend;
      if (bus_addr_i == A_BUSY) bus_rdata_o[NUM_DOM-1:0] = dom_busy;
      for (int d = 0; d < NUM_DOM; d++) begin
        if (bus_addr_i == 12'(A_DSTAT + 4 * d)) bus_rdata_o[0] = dom_on[d];
        if (bus_addr_i == 12'(A_DCTL + 4 * d)) begin
          bus_rdata_o[0] = dom_next_q[d];
          bus_rdata_o[8] = dom_pg[d];
        end
      end
      for (int m = 0; m < NUM_MOD; m++) begin
        if (bus_addr_i == 12'(A_MSTAT + 4 * m)) begin
          bus_rdata_o[1:0] = mod_state[m];
          bus_rdata_o[12]  = mod_clk_en_o[m];
        end
        if (bus_addr_i == 12'(A_MCTL + 4 * m)) bus_rdata_o = mod_ctl[m];
      end
    end
  end
endmodule

// File: rtl/pwr_sleep_ctrl_chk.sv
module pwr_sleep_ctrl_chk #(
  parameter int NUM_DOM      = 2,
  parameter int MODS_PER_DOM = 2,
  localparam int NUM_MOD     = NUM_DOM * MODS_PER_DOM
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     bus_req_i,
  input logic                     bus_we_i,
  input logic [11:0]              bus_addr_i,
  input logic [31:0]              bus_rdata_o,
  input logic [NUM_MOD-1:0]       mod_clk_en_o,
  input logic [NUM_DOM-1:0]       dom_busy,
  input logic [NUM_DOM-1:0]       dom_on,
  input logic [NUM_DOM-1:0]       dom_pend,
  input logic [NUM_MOD-1:0][1:0]  mod_state
);
  for (genvar m = 0; m < NUM_MOD; m++) begin : g_m
    localparam int D = m / MODS_PER_DOM;
    // R2
    mod_move_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mod_state[m] != $past(mod_state[m])) |-> ($past(dom_busy[D]) && !dom_busy[D]));
    // R3
    clk_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(mod_clk_en_o[m]) |-> $past(dom_busy[D]));
  end

  for (genvar d = 0; d < NUM_DOM; d++) begin : g_d
    // R5
    pend_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      dom_pend[d] |-> dom_busy[d]);
    // R5
    pend_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(dom_pend[d]) |-> dom_on[d]);
    // R7
    dom_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(dom_on[d]) |-> ($past(dom_busy[d]) && !dom_busy[d]));
  end

  // R10
  go_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_i && !bus_we_i && bus_addr_i == 12'h120) |-> (bus_rdata_o == 32'd0));
endmodule

bind pwr_sleep_ctrl pwr_sleep_ctrl_chk #(
  .NUM_DOM(NUM_DOM), .MODS_PER_DOM(MODS_PER_DOM)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .bus_req_i    (bus_req_i),
  .bus_we_i     (bus_we_i),
  .bus_addr_i   (bus_addr_i),
  .bus_rdata_o  (bus_rdata_o),
  .mod_clk_en_o (mod_clk_en_o),
  .dom_busy     (dom_busy),
  .dom_on       (dom_on),
  .dom_pend     (dom_pend),
  .mod_state    (mod_state)
);

// File: tb/sim_pwr_sleep_ctrl.sv
`timescale 1ns/1ps
module sim_pwr_sleep_ctrl;
  localparam int ND = 2, MPD = 2, NM = ND * MPD, TC = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [ND-1:0] pwr_req;
  logic [NM-1:0] clk_en, mod_rst_n;
  int cmp = 0, mis = 0;

  always #2.5 clk = ~clk;

  pwr_sleep_ctrl #(.NUM_DOM(ND), .MODS_PER_DOM(MPD), .TRANS_CYC(TC)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .bus_req_i(req), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .pwr_req_o(pwr_req), .mod_clk_en_o(clk_en), .mod_rst_no(mod_rst_n));

  // behavioural reference model
  int s_on[ND], s_nxt[ND], s_pg[ND], s_pend[ND], s_st[ND], s_cnt[ND], s_cap[ND];
  int s_req[NM], s_lrel[NM], s_frc[NM], s_mst[NM];

  task automatic model_reset();
    for (int d = 0; d < ND; d++) begin
      s_on[d] = 1; s_nxt[d] = 1; s_pg[d] = 0; s_pend[d] = 0;
      s_st[d] = 0; s_cnt[d] = 0; s_cap[d] = 1;
    end
    for (int m = 0; m < NM; m++) begin
      s_req[m] = 0; s_lrel[m] = 1; s_frc[m] = 0; s_mst[m] = 0;
    end
  endtask

  initial model_reset();

  always @(posedge clk) begin
    if (!rst_n) model_reset();
    else begin
      for (int m = 0; m < NM; m++) begin
        int d;
        d = m / MPD;
        if (s_st[d] == 2 && s_cnt[d] == 0 && (s_on[d] != 0 || s_frc[m] != 0))
          s_mst[m] = s_req[m];
      end
      for (int d = 0; d < ND; d++) begin
        bit go;
        go = req && we && addr == 12'h120 && wdata[d];
        if (s_st[d] == 0) begin
          if (go) begin
            s_cap[d] = s_nxt[d];
            if (s_on[d] == 0 && s_nxt[d] != 0) begin s_st[d] = 1; s_pend[d] = 1; end
            else begin s_st[d] = 2; s_cnt[d] = TC - 1; end
          end
        end else if (s_st[d] == 1) begin
          if (s_pg[d] != 0) begin
            s_pg[d] = 0; s_pend[d] = 0; s_on[d] = 1; s_st[d] = 2; s_cnt[d] = TC - 1;
          end
        end else begin
          if (s_cnt[d] == 0) begin s_st[d] = 0; s_on[d] = s_cap[d]; end
          else s_cnt[d] = s_cnt[d] - 1;
        end
      end
      if (req && we) begin
        for (int d = 0; d < ND; d++)
          if (addr == 12'h300 + 12'(4 * d)) begin
            s_nxt[d] = wdata[0];
            if (wdata[8]) s_pg[d] = 1;
          end
        for (int m = 0; m < NM; m++)
          if (addr == 12'hA00 + 12'(4 * m)) begin
            s_req[m] = wdata[1:0]; s_lrel[m] = wdata[8]; s_frc[m] = wdata[31];
          end
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    cmp++;
    if (got !== exp) begin
      mis++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // per-cycle comparison of the outputs against the model
  always @(negedge clk) begin
    if (rst_n) begin
      logic [ND-1:0] e_req;
      logic [NM-1:0] e_clk, e_rst;
      for (int d = 0; d < ND; d++) e_req[d] = (s_pend[d] != 0);
      for (int m = 0; m < NM; m++) begin
        e_clk[m] = (s_mst[m] == 3);
        e_rst[m] = (s_lrel[m] != 0) && (s_mst[m] >= 2);
      end
      chk("R5 pwr_req_o", 32'(pwr_req), 32'(e_req));
      chk("R3 mod_clk_en_o", 32'(clk_en), 32'(e_clk));
      chk("R4 mod_rst_no", 32'(mod_rst_n), 32'(e_rst));
    end
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] v);
    @(negedge clk); req = 1'b1; we = 1'b1; addr = a; wdata = v;
    @(negedge clk); req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] v);
    @(negedge clk); req = 1'b1; we = 1'b0; addr = a;
    #1 v = rdata; req = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(tag, v, exp);
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int i = 0; i < 200; i++) begin
      rd(12'h128, v);
      if (v == 0) break;
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", cmp, mis);
    $finish;
  endtask

  initial begin
    #1_000_000;
    mis++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd_chk("R1 domain0 status", 12'h200, 32'h1);
    rd_chk("R1 domain1 control", 12'h304, 32'h1);
    rd_chk("R1 busy", 12'h128, 32'h0);
    rd_chk("R1 pending", 12'h070, 32'h0);
    rd_chk("R1 module3 status", 12'h80C, 32'h0);
    rd_chk("R1 module0 control", 12'hA00, 32'h100);
    chk("R1 clk_en", 32'(clk_en), 32'h0);
    chk("R1 mod_rst_n", 32'(mod_rst_n), 32'h0);
    // R10 unmapped and go reads
    rd_chk("R10 unmapped 0x004", 12'h004, 32'h0);
    rd_chk("R10 go register", 12'h120, 32'h0);
    rd_chk("R10 domain beyond range", 12'h308, 32'h0);

    // R2, R9, R11: domain 0 transition
    wr(12'hA00, 32'h103);
    wr(12'hA04, 32'h002);
    wr(12'hA08, 32'h103);
    wr(12'h120, 32'h1);
    wr(12'h120, 32'h1);   // ignored, domain 0 busy
    for (int i = 0; i < TC - 4; i++) @(negedge clk);
    rd_chk("R9 busy before end", 12'h128, 32'h1);
    rd_chk("R9 busy cleared at original end", 12'h128, 32'h0);
    rd_chk("R2 module0 enabled", 12'h800, 32'h1003);
    rd_chk("R2 module1 clock disabled", 12'h804, 32'h0002);
    rd_chk("R11 module2 untouched", 12'h808, 32'h0);
    chk("R4 module1 held by local reset", 32'(mod_rst_n[1]), 32'h0);

    // R4 local reset independent of state
    wr(12'hA00, 32'h003);
    chk("R4 local reset asserted", 32'(mod_rst_n[0]), 32'h0);
    chk("R4 clock unaffected", 32'(clk_en[0]), 32'h1);
    rd_chk("R4 state unchanged", 12'h800, 32'h1003);
    wr(12'hA00, 32'h103);
    chk("R4 local reset released", 32'(mod_rst_n[0]), 32'h1);

    // R7 power down domain 1
    wr(12'h304, 32'h0);
    wr(12'h120, 32'h2);
    wait_idle();
    rd_chk("R7 domain1 off", 12'h204, 32'h0);
    rd_chk("R7 domain0 still on", 12'h200, 32'h1);

    // R8 force in an off domain
    wr(12'hA08, 32'h8000_0103);
    wr(12'hA0C, 32'h103);
    wr(12'h120, 32'h2);
    wait_idle();
    rd_chk("R8 forced module moves", 12'h808, 32'h1003);
    rd_chk("R8 unforced module held", 12'h80C, 32'h0);
    rd_chk("R8 domain stays off", 12'h204, 32'h0);

    // R5, R6 power-up handshake
    wr(12'h304, 32'h1);
    wr(12'h120, 32'h2);
    rd_chk("R5 pending set", 12'h070, 32'h2);
    chk("R5 pwr_req_o", 32'(pwr_req), 32'h2);
    repeat (10) @(negedge clk);
    rd_chk("R5 still busy", 12'h128, 32'h2);
    rd_chk("R5 module waits for power", 12'h80C, 32'h0);
    wr(12'h304, 32'h101);
    rd_chk("R5 pending cleared", 12'h070, 32'h0);
    rd_chk("R5 domain on", 12'h204, 32'h1);
    wait_idle();
    rd_chk("R5 module enabled after power", 12'h80C, 32'h1003);
    rd_chk("R6 power good self-cleared", 12'h304, 32'h1);
    repeat (4) @(negedge clk);
    summary();
  end
endmodule